// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block sits beside one small direct-mapped, write-back cache and keeps it coherent with its peers on a shared snooping bus. It uses a four-state invalidation protocol: Invalid, Shared (clean, possibly held by several caches), Exclusive (clean, held only here) and Modified (dirty, held only here). A processor issues one request at a time and holds it until a one-cycle ready pulse answers it. Misses, write upgrades and dirty evictions become single-cycle bus transactions: a bus read, a read-for-ownership, or a writeback. The controller issues these on its request side and watches every transaction of the other caches on its snoop side.

A wired-OR shared line lets the requester choose the fill state. Every snooping cache that holds the line raises the line during a bus read. A read miss that sees no peer copy installs the line as Exclusive. A later local write then upgrades it to Modified with no bus traffic, so a read followed by a write costs one transaction instead of two. Each line holds a single data word. The line index is the low address bits and the tag is the rest.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `ready_o` and `bus_req_o` are low, and the first access to any address needs a bus transaction.
- R2: A read miss issues a bus read (command code 1). It installs the line as Exclusive if `bus_shared_i` is low in the grant cycle, and as Shared if it is high. A read that hits a valid line issues no transaction.
- R3: A write that hits an Exclusive or Modified line completes with no bus transaction and leaves the line Modified.
- R4: A write that finds the line Invalid, Shared or under another tag issues a read-for-ownership (command code 2). It leaves the line Modified and holding the write data.
- R5: A snooped bus read whose address hits a valid local line raises `snp_shared_o`. An Exclusive copy drops to Shared. A Modified copy drives its data on `snp_data_o` with `snp_flush_o` high and then drops to Shared.
- R6: A snooped read-for-ownership that hits a valid local line invalidates it. Only a Modified copy raises `snp_flush_o` and supplies its data.
- R7: A miss whose index holds a Modified line under another tag first issues a writeback (command code 3) carrying the victim address and data. That line becomes Invalid, and the fill follows. Shared or Exclusive victims are dropped with no writeback.
- R8: A read returns the value most recently written to that address by any cache, or the memory value if no cache has written it.
- R9: At most one cache holds a line as Exclusive or Modified. On the bus this means at most one cache flushes in any cycle, and a flushing cache is the only one that reports a copy.
- R10: `ready_o` is high for exactly one cycle per request. A snoop cycle delays a local lookup by one cycle. The controller is never snooped while it holds the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Processor request, held until ready |
| we_i | input | 1 | Request is a write |
| addr_i | input | ADDR_W | Request word address |
| wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Read data, valid with ready |
| bus_req_o | output | 1 | Bus transaction requested |
| bus_gnt_i | input | 1 | Bus granted; transaction takes place this cycle |
| bus_cmd_o | output | 2 | 1 read, 2 read-for-ownership, 3 writeback |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_wdata_o | output | DATA_W | Writeback data |
| bus_rdata_i | input | DATA_W | Fill data from memory or a flushing peer |
| bus_shared_i | input | 1 | Wired-OR of the peers' shared responses |
| snp_valid_i | input | 1 | A peer transaction is on the bus |
| snp_cmd_i | input | 2 | Snooped command code |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_shared_o | output | 1 | This cache holds the snooped line |
| snp_flush_o | output | 1 | This cache supplies dirty data |
| snp_data_o | output | DATA_W | Flushed data |

## Verification
The assertions assume a bus that carries one transaction per cycle. The granted cache is never snooped in that cycle. Fill data comes from a flushing peer whenever one exists, and from memory otherwise. The bench provides exactly this with a combinational fixed-priority arbiter and a memory model that takes writebacks and flushes at the clock edge. The bench also keeps one processor request outstanding across the whole system at a time. As a result, a local lookup and a snoop of the same line never meet in one cycle, and every grant resolves before the next request starts.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_state_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_RDX  = 2'd2,
    CMD_WB   = 2'd3
  } bus_cmd_e;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  // port a: requester, full line write
  input  logic [IDX_W-1:0]       a_idx_i,
  input  logic                   a_we_i,
  input  mesi_state_e            a_state_i,
  input  logic [TAG_W-1:0]       a_tag_i,
  input  logic [DATA_W-1:0]      a_data_i,
  output mesi_state_e            a_state_o,
  output logic [TAG_W-1:0]       a_tag_o,
  output logic [DATA_W-1:0]      a_data_o,
  // port b: snooper, state-only write
  input  logic [IDX_W-1:0]       b_idx_i,
  input  logic                   b_we_i,
  input  mesi_state_e            b_state_i,
  output mesi_state_e            b_state_o,
  output logic [TAG_W-1:0]       b_tag_o,
  output logic [DATA_W-1:0]      b_data_o,
  output logic [LINES-1:0][1:0]  st_o
);

  mesi_state_e         st_arr   [LINES];
  logic [TAG_W-1:0]    tag_arr  [LINES];
  logic [DATA_W-1:0]   data_arr [LINES];

  for (genvar g = 0; g < LINES; g++) begin : gen_line
    mesi_state_e       st_r;
    logic [TAG_W-1:0]  tag_r;
    logic [DATA_W-1:0] data_r;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_r   <= ST_I;
        tag_r  <= '0;
        data_r <= '0;
      end else if (b_we_i && b_idx_i == IDX_W'(g)) begin
        st_r <= b_state_i;  // snoop wins
      end else if (a_we_i && a_idx_i == IDX_W'(g)) begin
        st_r   <= a_state_i;
        tag_r  <= a_tag_i;
        data_r <= a_data_i;
      end
    end

    assign st_arr[g]   = st_r;
    assign tag_arr[g]  = tag_r;
    assign data_arr[g] = data_r;
    assign st_o[g]     = st_r;
  end

  assign a_state_o = st_arr[a_idx_i];
  assign a_tag_o   = tag_arr[a_idx_i];
  assign a_data_o  = data_arr[a_idx_i];
  assign b_state_o = st_arr[b_idx_i];
  assign b_tag_o   = tag_arr[b_idx_i];
  assign b_data_o  = data_arr[b_idx_i];

  assert_one_writer_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_we_i && b_we_i && a_idx_i == b_idx_i));

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [TAG_W-1:0]  snp_tag_i,
  input  mesi_state_e       line_state_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              shared_o,
  output logic              flush_o,
  output logic [DATA_W-1:0] flush_data_o,
  output logic              upd_en_o,
  output mesi_state_e       upd_state_o
);

  logic hit, owned;

  assign hit          = snp_valid_i && line_state_i != ST_I && line_tag_i == snp_tag_i;
  assign owned        = line_state_i == ST_E || line_state_i == ST_M;
  assign flush_data_o = line_data_i;

  always_comb begin
    shared_o    = 1'b0;
    flush_o     = 1'b0;
    upd_en_o    = 1'b0;
    upd_state_o = line_state_i;
    unique case (snp_cmd_i)
      CMD_RD: begin
        shared_o    = hit;
        flush_o     = hit && line_state_i == ST_M;
        upd_en_o    = hit && owned;
        upd_state_o = ST_S;
      end
      CMD_RDX: begin
        flush_o     = hit && line_state_i == ST_M;
        upd_en_o    = hit;
        upd_state_o = ST_I;
      end
      default: ;  // writeback or idle: a peer's dirty line is never held here
    endcase
  end

endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              snp_busy_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  input  mesi_state_e       line_state_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              wr_en_o,
  output mesi_state_e       wr_state_o,
  output logic [TAG_W-1:0]  wr_tag_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_shared_i
);

  typedef enum logic [1:0] {F_IDLE, F_BUS, F_RESP} fsm_e;

  fsm_e              cur_q, nxt;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              hit, dirty_victim, owned;
  logic [DATA_W-1:0] fill_data;

  assign idx          = addr_i[IDX_W-1:0];
  assign tag          = addr_i[ADDR_W-1:IDX_W];
  assign hit          = line_state_i != ST_I && line_tag_i == tag;
  assign owned        = line_state_i == ST_E || line_state_i == ST_M;
  assign dirty_victim = !hit && line_state_i == ST_M;
  assign fill_data    = we_i ? wdata_i : bus_rdata_i;

  always_comb begin
    nxt         = cur_q;
    rdata_d     = rdata_q;
    wr_en_o     = 1'b0;
    wr_state_o  = line_state_i;
    wr_tag_o    = line_tag_i;
    wr_data_o   = line_data_i;
    bus_req_o   = 1'b0;
    bus_cmd_o   = CMD_NONE;
    bus_addr_o  = addr_i;
    bus_wdata_o = line_data_i;
    unique case (cur_q)
      F_IDLE: begin
        if (req_i && !snp_busy_i) begin
          if (!we_i && hit) begin
            rdata_d = line_data_i;
            nxt     = F_RESP;
          end else if (we_i && hit && owned) begin
            wr_en_o    = 1'b1;  // silent upgrade
            wr_state_o = ST_M;
            wr_data_o  = wdata_i;
            nxt        = F_RESP;
          end else begin
            nxt = F_BUS;
          end
        end
      end
      F_BUS: begin
        bus_req_o = 1'b1;
        if (dirty_victim) begin
          bus_cmd_o  = CMD_WB;
          bus_addr_o = {line_tag_i, idx};
          if (bus_gnt_i) begin
            wr_en_o    = 1'b1;
            wr_state_o = ST_I;
          end
        end else begin
          bus_cmd_o = we_i ? CMD_RDX : CMD_RD;
          if (bus_gnt_i) begin
            wr_en_o    = 1'b1;
            wr_tag_o   = tag;
            wr_data_o  = fill_data;
            wr_state_o = we_i ? ST_M : (bus_shared_i ? ST_S : ST_E);
            rdata_d    = fill_data;
            nxt        = F_RESP;
          end
        end
      end
      F_RESP:  nxt = F_IDLE;
      default: nxt = F_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= F_IDLE;
      rdata_q <= '0;
    end else begin
      cur_q   <= nxt;
      rdata_q <= rdata_d;
    end
  end

  assign ready_o = cur_q == F_RESP;
  assign rdata_o = rdata_q;

  assert_ready_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  assert_lookup_waits_snoop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == F_IDLE && req_i && snp_busy_i) |=> cur_q == F_IDLE);

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LINES  = 4,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_shared_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_shared_o,
  output logic              snp_flush_o,
  output logic [DATA_W-1:0] snp_data_o
);

  logic [IDX_W-1:0]     req_idx, snp_idx;
  logic [TAG_W-1:0]     req_tag, snp_tag;
  mesi_state_e          a_state, b_state, wr_state, upd_state;
  logic [TAG_W-1:0]     a_tag, b_tag, wr_tag;
  logic [DATA_W-1:0]    a_data, b_data, wr_data;
  logic                 wr_en, upd_en;
  logic [LINES-1:0][1:0] line_st;

  assign req_idx = addr_i[IDX_W-1:0];
  assign req_tag = addr_i[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr_i[IDX_W-1:0];
  assign snp_tag = snp_addr_i[ADDR_W-1:IDX_W];

  mesi_line_store #(
    .LINES (LINES),
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
  ) store_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_idx_i  (req_idx),
    .a_we_i   (wr_en),
    .a_state_i(wr_state),
    .a_tag_i  (wr_tag),
    .a_data_i (wr_data),
    .a_state_o(a_state),
    .a_tag_o  (a_tag),
    .a_data_o (a_data),
    .b_idx_i  (snp_idx),
    .b_we_i   (upd_en),
    .b_state_i(upd_state),
    .b_state_o(b_state),
    .b_tag_o  (b_tag),
    .b_data_o (b_data),
    .st_o     (line_st)
  );

  mesi_snoop_unit #(
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
  ) snoop_i (
    .snp_valid_i (snp_valid_i),
    .snp_cmd_i   (snp_cmd_i),
    .snp_tag_i   (snp_tag),
    .line_state_i(b_state),
    .line_tag_i  (b_tag),
    .line_data_i (b_data),
    .shared_o    (snp_shared_o),
    .flush_o     (snp_flush_o),
    .flush_data_o(snp_data_o),
    .upd_en_o    (upd_en),
    .upd_state_o (upd_state)
  );

  mesi_req_fsm #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W),
    .DATA_W(DATA_W)
  ) fsm_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .snp_busy_i  (snp_valid_i),
    .ready_o     (ready_o),
    .rdata_o     (rdata_o),
    .line_state_i(a_state),
    .line_tag_i  (a_tag),
    .line_data_i (a_data),
    .wr_en_o     (wr_en),
    .wr_state_o  (wr_state),
    .wr_tag_o    (wr_tag),
    .wr_data_o   (wr_data),
    .bus_req_o   (bus_req_o),
    .bus_gnt_i   (bus_gnt_i),
    .bus_cmd_o   (bus_cmd_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_rdata_i (bus_rdata_i),
    .bus_shared_i(bus_shared_i)
  );

  assert_fill_state_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_gnt_i && bus_req_o && bus_cmd_o == CMD_RD)
      |=> line_st[$past(req_idx)] == ($past(bus_shared_i) ? ST_S : ST_E));

  assert_silent_upgrade_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !ready_o && !snp_valid_i && a_state == ST_E && a_tag == req_tag)
      |=> ready_o && line_st[$past(req_idx)] == ST_M && !$past(bus_req_o));

  assert_rdx_owns_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_gnt_i && bus_req_o && bus_cmd_o == CMD_RDX) |=> line_st[$past(req_idx)] == ST_M);

  assert_rd_demotes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_cmd_i == CMD_RD && snp_shared_o) |=> line_st[$past(snp_idx)] == ST_S);

  assert_rdx_kills_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_cmd_i == CMD_RDX && b_state != ST_I && b_tag == snp_tag)
      |=> line_st[$past(snp_idx)] == ST_I);

  assert_wb_evicts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_gnt_i && bus_req_o && bus_cmd_o == CMD_WB) |=> line_st[$past(req_idx)] == ST_I);

  assert_no_self_snoop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_gnt_i |-> !snp_valid_i);

endmodule

// File: tb/mesi_snoop_ctrl_tb.sv
module mesi_snoop_ctrl_tb_top;
  localparam int NC = 3;
  localparam int AW = 4;
  localparam int LN = 2;
  localparam int DW = 16;
  localparam int NA = 1 << AW;
  localparam int S_I = 0, S_S = 1, S_E = 2, S_M = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [NC-1:0] req, we, ready, bus_req, gnt, snp_valid, snp_shared, snp_flush;
  logic [AW-1:0] addr      [NC];
  logic [DW-1:0] wdata     [NC];
  logic [DW-1:0] rdata     [NC];
  logic [1:0]    bus_cmd   [NC];
  logic [AW-1:0] bus_addr  [NC];
  logic [DW-1:0] bus_wdata [NC];
  logic [DW-1:0] snp_data  [NC];
  logic [DW-1:0] mem       [NA];

  int            gidx;
  logic          found, shared_any, flush_any;
  logic [DW-1:0] flush_val, bus_rd;

  always_comb begin
    gnt = '0; gidx = 0; found = 1'b0;
    for (int k = 0; k < NC; k++)
      if (!found && bus_req[k]) begin gnt[k] = 1'b1; gidx = k; found = 1'b1; end
    snp_valid = found ? ~gnt : '0;
    shared_any = |snp_shared;
    flush_any  = |snp_flush;
    flush_val  = '0;
    for (int k = 0; k < NC; k++) if (snp_flush[k]) flush_val = snp_data[k];
    bus_rd = flush_any ? flush_val : mem[bus_addr[gidx]];
  end

  for (genvar k = 0; k < NC; k++) begin : gen_c
    mesi_snoop_ctrl #(.ADDR_W(AW), .LINES(LN), .DATA_W(DW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .req_i(req[k]), .we_i(we[k]), .addr_i(addr[k]), .wdata_i(wdata[k]),
      .ready_o(ready[k]), .rdata_o(rdata[k]),
      .bus_req_o(bus_req[k]), .bus_gnt_i(gnt[k]), .bus_cmd_o(bus_cmd[k]),
      .bus_addr_o(bus_addr[k]), .bus_wdata_o(bus_wdata[k]),
      .bus_rdata_i(bus_rd), .bus_shared_i(shared_any),
      .snp_valid_i(snp_valid[k]), .snp_cmd_i(bus_cmd[gidx]), .snp_addr_i(bus_addr[gidx]),
      .snp_shared_o(snp_shared[k]), .snp_flush_o(snp_flush[k]), .snp_data_o(snp_data[k])
    );
  end

  // memory and bus counters
  int   txn_cnt [NC];
  int   flush_cnt;
  logic rd_shared;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NA; i++) mem[i] <= DW'(16'hA000 + i);
      for (int k = 0; k < NC; k++) txn_cnt[k] <= 0;
      flush_cnt <= 0;
      rd_shared <= 1'b0;
    end else if (found) begin
      txn_cnt[gidx] <= txn_cnt[gidx] + 1;
      if (bus_cmd[gidx] == 2'd3) mem[bus_addr[gidx]] <= bus_wdata[gidx];
      if (flush_any) begin
        mem[bus_addr[gidx]] <= flush_val;
        flush_cnt <= flush_cnt + 1;
      end
      if (bus_cmd[gidx] == 2'd1) rd_shared <= shared_any;
    end
  end

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // R9: port-level single-owner check every cycle
  always @(negedge clk) begin
    if (rst_n && flush_any) begin
      n_tests++;
      if ($countones(snp_flush) != 1 ||
          (bus_cmd[gidx] == 2'd1 && $countones(snp_shared) != 1)) begin
        n_fail++;
        $display("FAIL R9 owners: actual flush=%0d shared=%0d expected 1",
                 $countones(snp_flush), $countones(snp_shared));
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // reference model
  int            mst  [NC][LN];
  int            mtag [NC][LN];
  logic [DW-1:0] gold [NA];

  task automatic do_op(input int c, input bit w, input int a, input logic [DW-1:0] d);
    int idx, tg, t0, f0, wait_n, exp_txn;
    bit hit, need, wb, oh, om;
    string rq;
    idx = a % LN; tg = a / LN;
    hit = mst[c][idx] != S_I && mtag[c][idx] == tg;
    need = w ? !(hit && (mst[c][idx] == S_E || mst[c][idx] == S_M)) : !hit;
    wb = need && !hit && mst[c][idx] == S_M;
    exp_txn = need ? (wb ? 2 : 1) : 0;
    oh = 0; om = 0;
    for (int k = 0; k < NC; k++)
      if (k != c && mst[k][idx] != S_I && mtag[k][idx] == tg) begin
        oh = 1;
        if (mst[k][idx] == S_M) om = 1;
      end
    t0 = txn_cnt[c]; f0 = flush_cnt;
    req[c] = 1'b1; we[c] = w; addr[c] = AW'(a); wdata[c] = d;
    wait_n = 0;
    do begin
      @(negedge clk);
      wait_n++;
    end while (!ready[c] && wait_n < 100);
    if (wait_n >= 100) begin
      chk(0, "R10", "ready timeout", 0, 1);
      req[c] = 1'b0;
      return;
    end
    if (!w) chk(rdata[c] == gold[a], "R8", "read data", int'(rdata[c]), int'(gold[a]));
    req[c] = 1'b0;
    if (wb) rq = "R7";
    else if (w) rq = hit && mst[c][idx] == S_E ? "R3" : "R4";
    else rq = "R2";
    chk(txn_cnt[c] - t0 == exp_txn, rq, "bus transactions", txn_cnt[c] - t0, exp_txn);
    chk(flush_cnt - f0 == ((need && om) ? 1 : 0), w ? "R6" : "R5", "peer flushes",
        flush_cnt - f0, (need && om) ? 1 : 0);
    if (!w && need) chk(rd_shared == oh, "R5", "shared response", int'(rd_shared), int'(oh));
    @(negedge clk);
    chk(!ready[c], "R10", "ready one cycle", int'(ready[c]), 0);
    if (need) begin
      for (int k = 0; k < NC; k++)
        if (k != c && mst[k][idx] != S_I && mtag[k][idx] == tg)
          mst[k][idx] = w ? S_I : S_S;
      mtag[c][idx] = tg;
      mst[c][idx] = w ? S_M : (oh ? S_S : S_E);
    end else if (w) mst[c][idx] = S_M;
    if (w) gold[a] = d;
  endtask

  initial begin
    logic [31:0] seed;
    req = '0; we = '0;
    for (int k = 0; k < NC; k++) begin
      addr[k] = '0; wdata[k] = '0;
      for (int l = 0; l < LN; l++) begin mst[k][l] = S_I; mtag[k][l] = 0; end
    end
    for (int i = 0; i < NA; i++) gold[i] = DW'(16'hA000 + i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == '0 && bus_req == '0, "R1", "idle after reset",
        int'({ready, bus_req}), 0);
    // R1: first read misses in every cache
    do_op(0, 0, 5, '0);
    // pairwise sweep over all ordered cache pairs and read/write patterns
    for (int a = 0; a < NC; a++)
      for (int b = 0; b < NC; b++) begin
        if (a == b) continue;
        for (int p = 0; p < 4; p++) begin
          int ad;
          ad = (a * 4 + b * 2 + p) % NA;
          do_op(a, p[1], ad, DW'(a * 256 + b * 16 + p));
          do_op(b, p[0], ad, DW'(a * 256 + b * 16 + p + 8));
          do_op(NC - a - b, 0, ad, '0);
          do_op(a, 0, ad, '0);
          do_op(a, 1, ad, DW'(16'h5000 + ad));
        end
      end
    // R7: dirty eviction, then peers read the written-back value
    do_op(0, 1, 0, 16'h1234);
    do_op(0, 0, 2, '0);
    do_op(1, 0, 0, '0);
    do_op(0, 0, 4, '0);
    do_op(2, 1, 4, 16'h4444);
    do_op(2, 1, 6, 16'h6666);
    do_op(1, 0, 4, '0);
    // pseudo-random mix
    seed = 32'h1ACE_0001;
    for (int n = 0; n < 600; n++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      do_op(int'(seed[30:29]) % NC, seed[27], int'(seed[20:17]), seed[15:0]);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule